// File: doc/BRIEF.md
# Serial Controller Interrupt Enable and Priority Unit

This unit is the interrupt path of a 16550-style serial controller. Software programs a four-bit interrupt enable register and the unit gathers four interrupt sources from the receiver, transmitter and modem logic: receiver line errors, received data available, transmit holding register empty, and modem line changes. It drives one interrupt request and an identification byte that names the most urgent pending source.

Line errors and modem line changes are latched. They stay pending until software reads the matching status register. Received data follows the receiver's data-available level. The transmit-empty condition is latched when the holding register becomes empty. It is cleared when software writes the holding register, or when software reads the identification byte while that byte reports transmit-empty. Pending state is kept whether or not the source is enabled. The enable bits only gate which pending sources reach the request output and the identification byte.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the request output is low and the identification byte reads 0x01.
- R2: Enable bits 0..3 (0 data ready, 1 transmit empty, 2 line status, 3 modem status) are written by an enable write and read back. Bits 7..4 always read 0 whatever is written.
- R3: A pulse on any of the four error inputs (overrun, parity, framing, break) latches a line status pending. A status register read clears it, unless a new error arrives in the same cycle, in which case it stays pending.
- R4: The data ready source is pending exactly while the receive-available input is high.
- R5: Transmit-empty becomes pending in the cycle after the empty input rises, or after an enable write that sets bit 1 from 0 while the empty input is high. It is cleared by a holding register write, and the clear wins over a simultaneous set.
- R6: Any change of the four tracked modem lines latches a modem pending. A modem status read clears it, unless a change arrives in the same cycle.
- R7: The request output is high exactly when some pending source has its enable bit set. Pending state is latched even while the enable bit is clear.
- R8: The identification byte has bit 0 low when a request is active, bits 3..1 carrying 011 (line status), 010 (data ready), 001 (transmit empty) or 000 (modem / none), and bits 7..4 zero. Priority runs line status, data ready, transmit empty, modem.
- R9: Reading the identification byte clears transmit-empty only when transmit-empty is the reported source. The read leaves every other source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| err_set | input | 4 | Error pulses: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_avail | input | 1 | Receive data available level |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_lines | input | 4 | Tracked modem status lines |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |

## Verification
The hardest situation to reach is a race between a clearing access and a fresh setting event in the same cycle. Examples are a status read that meets a new error pulse, and a holding register write that meets a rising empty edge. Another is an identification read taken while a higher-priority source hides transmit-empty. Directed sequences build each race on purpose. A long random phase then drives strobes, pulses and line changes densely, so that such overlaps recur many times. A behavioural model is compared against all outputs on every cycle.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_rdata,
  input  logic [3:0] err_set,
  input  logic       lsr_rd,
  input  logic       rx_avail,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic [3:0] msr_lines,
  input  logic       msr_rd,
  input  logic       iir_rd,
  output logic       irq,
  output logic [7:0] iir
);
  logic [3:0] ier_q;
  logic       ls_pend, thre_pend, ms_pend, thr_q;
  logic [3:0] msr_q;
  logic [3:0] act;
  logic [2:0] code;

  assign act = {ms_pend, ls_pend, thre_pend, rx_avail} & ier_q;

  always_comb begin
    if (act[2])      code = 3'b011;
    else if (act[0]) code = 3'b010;
    else if (act[1]) code = 3'b001;
    else             code = 3'b000;
  end

  assign irq       = |act;
  assign iir       = {4'b0000, code, ~irq};
  assign ier_rdata = {4'b0000, ier_q};

  wire thre_set = (thr_empty & ~thr_q) |
                  (ier_wr & ier_wdata[1] & ~ier_q[1] & thr_empty);
  wire thre_clr = thr_wr | (iir_rd & (code == 3'b001) & irq);
  wire ms_chg   = |(msr_lines ^ msr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q     <= 4'h0;
      ls_pend   <= 1'b0;
      thre_pend <= 1'b0;
      ms_pend   <= 1'b0;
      thr_q     <= 1'b0;
      msr_q     <= 4'h0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata[3:0];
      if (|err_set)    ls_pend <= 1'b1;
      else if (lsr_rd) ls_pend <= 1'b0;
      if (thre_clr)      thre_pend <= 1'b0;
      else if (thre_set) thre_pend <= 1'b1;
      if (ms_chg)      ms_pend <= 1'b1;
      else if (msr_rd) ms_pend <= 1'b0;
      thr_q <= thr_empty;
      msr_q <= msr_lines;
    end
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ier_rdata,
  input logic [3:0] err_set,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic [3:0] msr_lines,
  input logic [3:0] msr_q,
  input logic       msr_rd,
  input logic       irq,
  input logic [7:0] iir,
  input logic       ls_pend,
  input logic       thre_pend,
  input logic       ms_pend
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[7:4] == 4'h0);
  a_r8_iir_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    iir[7:4] == 4'h0);
  a_r7_irq_matches_iir: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iir[0]);
  a_r3_err_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ls_pend);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_set == 4'h0) |=> !ls_pend);
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend);
  a_r6_change_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_lines != msr_q) |=> ms_pend);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && msr_lines == msr_q) |=> !ms_pend);
endmodule

bind uart_irq_ctrl uart_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ier_rdata(ier_rdata), .err_set(err_set),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .msr_lines(msr_lines), .msr_q(msr_q),
  .msr_rd(msr_rd), .irq(irq), .iir(iir), .ls_pend(ls_pend),
  .thre_pend(thre_pend), .ms_pend(ms_pend)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, lsr_rd = 0, rx_avail = 0, thr_empty = 0, thr_wr = 0;
  logic msr_rd = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic [3:0] err_set = 0, msr_lines = 0;
  logic [7:0] ier_rdata, iir;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl dut_i (.*);

  // behavioural reference
  int m_ier, m_ls, m_thre, m_ms, m_thr_prev, m_msr_prev;

  function automatic int m_code();
    int en[4], pd[4];
    pd[0] = rx_avail; pd[1] = m_thre; pd[2] = m_ls; pd[3] = m_ms;
    for (int i = 0; i < 4; i++) en[i] = (m_ier >> i) & 1;
    if (pd[2] && en[2]) return 3;
    if (pd[0] && en[0]) return 2;
    if (pd[1] && en[1]) return 1;
    if (pd[3] && en[3]) return 0;
    return -1;
  endfunction

  always @(posedge clk) begin
    int c, nls, nth, nms;
    if (!rst_n) begin
      m_ier = 0; m_ls = 0; m_thre = 0; m_ms = 0; m_thr_prev = 0; m_msr_prev = 0;
    end else begin
      c = m_code();
      nls = m_ls; nth = m_thre; nms = m_ms;
      if (lsr_rd) nls = 0;
      if (err_set != 0) nls = 1;
      if (msr_rd) nms = 0;
      if (msr_lines != m_msr_prev) nms = 1;
      if ((thr_empty && !m_thr_prev) ||
          (ier_wr && ier_wdata[1] && !m_ier[1] && thr_empty)) nth = 1;
      if (thr_wr || (iir_rd && c == 1)) nth = 0;
      if (ier_wr) m_ier = ier_wdata & 8'h0F;
      m_ls = nls; m_thre = nth; m_ms = nms;
      m_thr_prev = thr_empty; m_msr_prev = msr_lines;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // compare all outputs every cycle, away from the edge
  always @(negedge clk) if (rst_n) begin
    int c;
    c = m_code();
    chk("R2", ier_rdata, m_ier);
    chk("R7", irq, c >= 0);
    chk("R8", iir, (c >= 0) ? (c << 1) : 1);
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
    ier_wr = 0; lsr_rd = 0; thr_wr = 0; msr_rd = 0; iir_rd = 0; err_set = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    #1;
    chk("R1", ier_rdata, 0); chk("R1", irq, 0); chk("R1", iir, 8'h01);
    // R2: upper bits ignored
    ier_wr = 1; ier_wdata = 8'hF0; step();
    chk("R2", ier_rdata, 0);
    // R3 / R7: latched while disabled, then enabled
    err_set = 4'b0100; step();
    chk("R7", irq, 0);
    ier_wr = 1; ier_wdata = 8'h04; step();
    chk("R3", iir, 8'h06);
    lsr_rd = 1; err_set = 4'b0001; step();
    chk("R3", irq, 1);
    lsr_rd = 1; step();
    chk("R3", irq, 0);
    // R4
    ier_wr = 1; ier_wdata = 8'h0F; rx_avail = 1; step();
    chk("R4", iir, 8'h04);
    rx_avail = 0; step();
    chk("R4", irq, 0);
    // R5 / R9: empty rises, hidden behind data ready
    rx_avail = 1; thr_empty = 1; step();
    iir_rd = 1; step();
    rx_avail = 0; #1;
    chk("R9", iir, 8'h02);
    iir_rd = 1; step();
    chk("R5", irq, 0);
    thr_empty = 0; step();
    thr_empty = 1; thr_wr = 1; step();
    chk("R5", irq, 0);
    // R5 enable path
    ier_wr = 1; ier_wdata = 8'h00; step();
    ier_wr = 1; ier_wdata = 8'h02; step();
    chk("R5", iir, 8'h02);
    thr_wr = 1; step();
    // R6
    ier_wr = 1; ier_wdata = 8'h08; msr_lines = 4'h3; step(2);
    chk("R6", iir, 8'h00);
    msr_rd = 1; step();
    chk("R6", irq, 0);
    msr_rd = 1; msr_lines = 4'h1; step();
    chk("R6", irq, 1);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      ier_wr = ($urandom % 8) == 0; ier_wdata = 8'($urandom);
      err_set = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      lsr_rd = $urandom % 4 == 0; msr_rd = $urandom % 4 == 0;
      iir_rd = $urandom % 3 == 0; thr_wr = $urandom % 5 == 0;
      if ($urandom % 4 == 0) rx_avail = ~rx_avail;
      if ($urandom % 4 == 0) thr_empty = ~thr_empty;
      if ($urandom % 7 == 0) msr_lines = 4'($urandom);
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule